// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus on which some target keeps SDA low, which typically happens when a reset interrupts a transfer. The block never drives SDA. It watches SDA through a synchroniser and, when a clear is started, generates SCL clocks one at a time as open-drain pulses. SDA is examined before every new pulse. The sequence stops with success as soon as SDA reads high, or with failure once a fixed number of clocks has been spent.

A clear starts in one of two ways. A command input requests it, or it starts by itself when SDA reads low in the cycle right after the controller is enabled. A separate command produces exactly one SCL clock without looking at SDA. Each pulse lasts a programmable number of system clocks in its low half and in its high half. The high half is counted only from the moment SCL is really seen high, so a target that stretches the clock makes the pulse longer.

After each pulse the block emits a strobe that clears the bus-error flags the pulse may have raised. After a successful clear it sends a reset pulse to the protocol engine, which has lost step with the bus. While a clear or a single pulse is running, transfer requests are refused.

Top module: `i2c_bus_clear`

## Requirements
- R1: `sda_level` shows the SDA input after a two-stage synchroniser. It is valid in every state, including while `enable` is low. The synchroniser resets to 1.
- R2: When `enable` is 1 and the block is idle, a pulse on `clr_req` starts a clear. SDA is checked before each pulse. If SDA reads high, the sequence ends with `done`=1, `fail`=0 and no further pulse. `pulse_cnt` then holds the number of pulses generated (0 if SDA was already high). `clr_req` wins if it arrives together with `one_shot`.
- R3: In each pulse `scl_oe`=1 (SCL pulled low) for exactly max(`half_period`,1) system clocks, after which SCL is released. The high half is counted as max(`half_period`,1) clocks, starting only once the synchronised SCL reads high, so clock stretching lengthens it. SCL is only ever pulled low or released, and SDA is never driven.
- R4: If SDA still reads low after 9 pulses, the sequence ends with `fail`=1, `done`=0 and `pulse_cnt`=9, and no tenth pulse follows.
- R5: When the block is enabled and idle, a pulse on `one_shot` generates exactly one SCL clock. `busy` stays 1 until that clock's high half ends and then clears by itself. The result is `pulse_cnt`=1, `done`=0, `fail`=0 and no engine reset.
- R6: If `enable` rises while `sda_level` is 0, a clear starts without any `clr_req`. If `enable` rises while `sda_level` is 1, no pulse is generated.
- R7: `engine_rst` is a single-cycle pulse that appears exactly once per successful clear, in the cycle `done` becomes 1. It never follows a failed clear or a single pulse.
- R8: `flag_clr` pulses for one cycle after every completed SCL pulse, so it pulses as many times as `pulse_cnt` counts.
- R9: `xfer_grant` is 1 one cycle after `xfer_req`=1 only if the block was enabled and idle and nothing started in that cycle. It is 0 throughout a clear.
- R10: Setting `enable` to 0 stops any sequence: SCL is released and `busy` falls. While `enable` is 0, `clr_req` and `one_shot` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable |
| clr_req | input | 1 | Start a bus clear (pulse) |
| one_shot | input | 1 | Generate one SCL clock (pulse) |
| half_period | input | HP_W | SCL half-period in system clocks (0 acts as 1) |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| xfer_req | input | 1 | Protocol engine asks to start a transfer |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_level | output | 1 | Synchronised SDA level |
| busy | output | 1 | Clear or single pulse in progress |
| done | output | 1 | Last clear succeeded |
| fail | output | 1 | Last clear gave up after 9 pulses |
| pulse_cnt | output | CNT_W | Pulses generated by the last command |
| flag_clr | output | 1 | Clear bus-error flags strobe |
| engine_rst | output | 1 | Protocol engine reset strobe |
| xfer_grant | output | 1 | Transfer request accepted |

## Verification
The hardest situations to reach are the ones where the end of a clear depends on when a target lets SDA go relative to a stretched SCL high half. The bench therefore models a stuck target that releases SDA on a chosen SCL rising edge and that holds SCL low for a chosen number of extra cycles after each low half. Random hold counts spanning zero through beyond the nine-pulse cap, random half-periods and random stretch lengths drive both the success path and the failure path. Directed cases cover a zero half-period, the automatic start at enable, and an abort in the middle of a pulse.

// File: rtl/busclr_pkg.sv
package busclr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOW,
    ST_WAIT_HI,
    ST_HIGH
  } clr_state_t;
endpackage

// File: rtl/busclr_sync.sv
module busclr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/busclr_timer.sv
module busclr_timer #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HP_W-1:0] half_period,
  input  logic            load,
  input  logic            dec,
  output logic            zero
);
  logic [HP_W-1:0] cnt;
  logic [HP_W-1:0] reload;

  always_comb begin
    if (half_period == '0) reload = '0;
    else reload = half_period - HP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= reload;
    else if (dec && cnt != '0) cnt <= cnt - HP_W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/busclr_fsm.sv
module busclr_fsm
  import busclr_pkg::*;
#(
  parameter int MAX_PULSES = 9,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             clr_req,
  input  logic             one_shot,
  input  logic             xfer_req,
  input  logic             sda_s,
  input  logic             scl_s,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic             tmr_dec,
  output logic             scl_oe,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] pulse_cnt,
  output logic             flag_clr,
  output logic             engine_rst,
  output logic             xfer_grant
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PULSES);

  clr_state_t state;
  logic       en_q;
  logic       single;
  logic       seen_low;
  logic       auto_go;
  logic       clr_go;
  logic       shot_go;
  logic       at_cap;

  assign auto_go = enable && !en_q && !sda_s;
  assign clr_go  = enable && (state == ST_IDLE) && (clr_req || auto_go);
  assign shot_go = enable && (state == ST_IDLE) && !clr_go && one_shot;
  assign at_cap  = (pulse_cnt == CAP);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    if (enable) begin
      case (state)
        ST_IDLE:    tmr_load = shot_go;
        ST_CHECK:   tmr_load = !sda_s && !at_cap;
        ST_WAIT_HI: tmr_load = scl_s && seen_low;
        default:    tmr_load = 1'b0;
      endcase
    end
  end

  assign tmr_dec = (state == ST_LOW) || (state == ST_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      en_q       <= 1'b0;
      single     <= 1'b0;
      seen_low   <= 1'b0;
      scl_oe     <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      pulse_cnt  <= '0;
      flag_clr   <= 1'b0;
      engine_rst <= 1'b0;
      xfer_grant <= 1'b0;
    end else begin
      en_q       <= enable;
      flag_clr   <= 1'b0;
      engine_rst <= 1'b0;
      xfer_grant <= xfer_req && enable && (state == ST_IDLE) && !clr_go && !shot_go;
      if (!enable) begin
        state  <= ST_IDLE;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (clr_go || shot_go) begin
              single    <= shot_go;
              pulse_cnt <= '0;
              done      <= 1'b0;
              fail      <= 1'b0;
            end
            if (clr_go) begin
              state <= ST_CHECK;
            end else if (shot_go) begin
              state    <= ST_LOW;
              scl_oe   <= 1'b1;
              seen_low <= 1'b0;
            end
          end
          ST_CHECK: begin
            if (sda_s) begin
              done       <= 1'b1;
              engine_rst <= 1'b1;
              state      <= ST_IDLE;
            end else if (at_cap) begin
              fail  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state    <= ST_LOW;
              scl_oe   <= 1'b1;
              seen_low <= 1'b0;
            end
          end
          ST_LOW: begin
            if (!scl_s) seen_low <= 1'b1;
            if (tmr_zero) begin
              scl_oe <= 1'b0;
              state  <= ST_WAIT_HI;
            end
          end
          ST_WAIT_HI: begin
            if (!scl_s) seen_low <= 1'b1;
            if (scl_s && seen_low) state <= ST_HIGH;
          end
          ST_HIGH: begin
            if (tmr_zero) begin
              pulse_cnt <= pulse_cnt + CNT_W'(1);
              flag_clr  <= 1'b1;
              state     <= single ? ST_IDLE : ST_CHECK;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int HP_W        = 8,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             clr_req,
  input  logic             one_shot,
  input  logic [HP_W-1:0]  half_period,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic             xfer_req,
  output logic             scl_oe,
  output logic             sda_level,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] pulse_cnt,
  output logic             flag_clr,
  output logic             engine_rst,
  output logic             xfer_grant
);
  logic [1:0] line_s;
  logic       sda_s;
  logic       scl_s;
  logic       tmr_load;
  logic       tmr_dec;
  logic       tmr_zero;

  busclr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  assign sda_s     = line_s[0];
  assign scl_s     = line_s[1];
  assign sda_level = sda_s;

  busclr_timer #(.HP_W(HP_W)) i_timer (
    .clk         (clk),
    .rst         (rst),
    .half_period (half_period),
    .load        (tmr_load),
    .dec         (tmr_dec),
    .zero        (tmr_zero)
  );

  busclr_fsm #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .clr_req    (clr_req),
    .one_shot   (one_shot),
    .xfer_req   (xfer_req),
    .sda_s      (sda_s),
    .scl_s      (scl_s),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_dec    (tmr_dec),
    .scl_oe     (scl_oe),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .pulse_cnt  (pulse_cnt),
    .flag_clr   (flag_clr),
    .engine_rst (engine_rst),
    .xfer_grant (xfer_grant)
  );
endmodule

// File: rtl/busclr_chk.sv
module busclr_chk #(
  parameter int MAX_PULSES = 9,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             flag_clr,
  input logic             engine_rst,
  input logic             xfer_grant,
  input logic             scl_oe
);
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= CNT_W'(MAX_PULSES)); // R4

  AST_FAIL_AT_CAP: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> pulse_cnt == CNT_W'(MAX_PULSES)); // R4

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R2

  AST_RST_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    engine_rst |-> (done && !busy)); // R7

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    engine_rst |=> !engine_rst); // R7

  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !xfer_grant); // R9

  AST_FLAG_RELEASED: assert property (@(posedge clk) disable iff (rst)
    flag_clr |-> !scl_oe); // R8
endmodule

bind i2c_bus_clear busclr_chk #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .fail       (fail),
  .pulse_cnt  (pulse_cnt),
  .flag_clr   (flag_clr),
  .engine_rst (engine_rst),
  .xfer_grant (xfer_grant),
  .scl_oe     (scl_oe)
);

// File: tb/test_i2c_bus_clear.sv
`timescale 1ns/1ps
module test_i2c_bus_clear;
  localparam int HP_W = 8;
  localparam int MAXP = 9;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, clr_req = 1'b0, one_shot = 1'b0, xfer_req = 1'b0;
  logic [HP_W-1:0] half_period = 8'd4;
  logic scl_oe, sda_level, busy, done, fail, flag_clr, engine_rst, xfer_grant;
  logic [CW-1:0] pulse_cnt;

  // bus model: stuck target releasing SDA on the hold_k-th SCL rise, stretching SCL
  int  hold_k = 0;
  int  stretch_extra = 0;
  int  stretch_ctr = 0;
  int  rise_cnt = 0;
  logic scl_bus, sda_bus, scl_bus_q = 1'b1, oe_q = 1'b0;

  assign scl_bus = !(scl_oe || (stretch_ctr > 0));
  assign sda_bus = (rise_cnt >= hold_k);

  int checks = 0, fails = 0, cycles = 0;
  int low_len = 0, gap_len = 0, bad_low = 0, min_gap = 1000000, npulse_seen = 0;
  int n_flag = 0, n_eng = 0, exp_hp = 4;

  i2c_bus_clear #(.HP_W(HP_W), .MAX_PULSES(MAXP)) i_i2c_bus_clear (
    .clk(clk), .rst(rst), .enable(enable), .clr_req(clr_req), .one_shot(one_shot),
    .half_period(half_period), .sda_i(sda_bus), .scl_i(scl_bus), .xfer_req(xfer_req),
    .scl_oe(scl_oe), .sda_level(sda_level), .busy(busy), .done(done), .fail(fail),
    .pulse_cnt(pulse_cnt), .flag_clr(flag_clr), .engine_rst(engine_rst),
    .xfer_grant(xfer_grant)
  );

  always #10 clk = ~clk;

  function automatic int hp_eff(int hp);
    return (hp == 0) ? 1 : hp;
  endfunction
  function automatic int exp_cnt(int k);
    return (k > MAXP) ? MAXP : k;
  endfunction
  function automatic logic exp_fail(int k);
    return k > MAXP;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor at negedge: bus model update and pulse measurement
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
    if (stretch_ctr > 0) stretch_ctr--;
    if (scl_oe && !oe_q) begin
      stretch_ctr = exp_hp + stretch_extra;
      if (npulse_seen > 0 && gap_len < min_gap) min_gap = gap_len;
      low_len = 0;
    end
    if (scl_oe) low_len++;
    if (!scl_oe && oe_q) begin
      if (low_len != exp_hp) bad_low++;
      npulse_seen++;
      gap_len = 0;
    end
    if (!scl_oe) gap_len++;
    if (scl_bus && !scl_bus_q) rise_cnt++;
    if (flag_clr) n_flag++;
    if (engine_rst) n_eng++;
    scl_bus_q = scl_bus;
    oe_q = scl_oe;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep(int k, int hp, int s);
    hold_k = k; rise_cnt = 0; stretch_extra = s;
    half_period = HP_W'(hp); exp_hp = hp_eff(hp);
    bad_low = 0; min_gap = 1000000; npulse_seen = 0; n_flag = 0; n_eng = 0;
    step(4);
  endtask

  task automatic wait_idle();
    while (busy) step(1);
    step(2);
  endtask

  task automatic run_clear(string tag, int k, int hp, int s);
    prep(k, hp, s);
    clr_req = 1'b1; step(1); clr_req = 1'b0;
    wait_idle();
    check({tag, " R2 pulse_cnt"}, pulse_cnt, exp_cnt(k));
    check({tag, " R4 fail"}, fail, exp_fail(k));
    check({tag, " R2 done"}, done, !exp_fail(k));
    check({tag, " R3 low phase"}, bad_low, 0);
    if (exp_cnt(k) >= 2)
      check({tag, " R3 high phase min"}, (min_gap >= exp_hp + s) ? 1 : 0, 1);
    check({tag, " R8 flag strobes"}, n_flag, exp_cnt(k));
    check({tag, " R7 engine reset"}, n_eng, exp_fail(k) ? 0 : 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    hold_k = 100;
    step(3);
    rst = 1'b0;
    step(4);
    // reset state
    check("R10 reset scl_oe", scl_oe, 0);
    check("R2 reset busy", busy, 0);
    check("R2 reset done", done, 0);
    check("R4 reset fail", fail, 0);
    check("R2 reset cnt", pulse_cnt, 0);
    // R1: level visible while disabled
    check("R1 sda low while disabled", sda_level, 0);
    hold_k = 0; step(3);
    check("R1 sda high while disabled", sda_level, 1);
    hold_k = 100; step(3);
    // R10: commands ignored while disabled
    clr_req = 1'b1; one_shot = 1'b1; step(1); clr_req = 1'b0; one_shot = 1'b0;
    step(5);
    check("R10 disabled busy", busy, 0);
    check("R10 disabled scl_oe", scl_oe, 0);
    check("R10 disabled rises", rise_cnt, 0);

    // R6: auto start at enable with SDA low
    prep(3, 2, 0);
    enable = 1'b1;
    step(2);
    check("R6 auto start busy", busy, 1);
    // R9: grant refused while busy
    xfer_req = 1'b1; step(2);
    check("R9 grant while busy", xfer_grant, 0);
    xfer_req = 1'b0;
    wait_idle();
    check("R6 auto pulse_cnt", pulse_cnt, 3);
    check("R6 auto done", done, 1);
    check("R7 auto engine reset", n_eng, 1);

    // R6: enable rise with SDA high does nothing
    enable = 1'b0; prep(0, 3, 0);
    enable = 1'b1; step(6);
    check("R6 no auto busy", busy, 0);
    check("R6 no auto rises", rise_cnt, 0);
    check("R6 no auto cnt", pulse_cnt, 3);

    // R9: grant when idle
    xfer_req = 1'b1; step(2);
    check("R9 grant idle", xfer_grant, 1);
    xfer_req = 1'b0; step(2);
    check("R9 grant drops", xfer_grant, 0);

    // directed clears
    run_clear("k0", 0, 3, 0);
    run_clear("k9", 9, 2, 1);
    run_clear("k10", 10, 3, 0);
    run_clear("hp0", 4, 0, 0);
    run_clear("hp1s3", 5, 1, 3);

    // R5: single pulse
    prep(100, 5, 2);
    one_shot = 1'b1; step(1); one_shot = 1'b0;
    step(1);
    check("R5 one-shot busy", busy, 1);
    wait_idle();
    check("R5 one-shot cnt", pulse_cnt, 1);
    check("R5 one-shot rises", rise_cnt, 1);
    check("R5 one-shot done", done, 0);
    check("R5 one-shot fail", fail, 0);
    check("R5 one-shot low phase", bad_low, 0);
    check("R5 one-shot no engine reset", n_eng, 0);
    check("R8 one-shot flag", n_flag, 1);

    // R2: clr_req wins over one_shot
    prep(2, 2, 0);
    clr_req = 1'b1; one_shot = 1'b1; step(1); clr_req = 1'b0; one_shot = 1'b0;
    wait_idle();
    check("R2 priority cnt", pulse_cnt, 2);
    check("R2 priority done", done, 1);

    // R10: abort mid-sequence
    prep(100, 6, 0);
    clr_req = 1'b1; step(1); clr_req = 1'b0;
    step(5);
    enable = 1'b0; step(2);
    check("R10 abort busy", busy, 0);
    check("R10 abort scl_oe", scl_oe, 0);
    hold_k = 0; step(4);
    enable = 1'b1; step(2);

    // random clears
    for (int i = 0; i < 12; i++) begin
      int k, hp, s;
      k  = $urandom % 12;
      hp = $urandom % 7;
      s  = $urandom % 4;
      run_clear($sformatf("rand%0d", i), k, hp, s);
    end

    summary();
  end
endmodule